// File: doc/BRIEF.md
# Converter Protection Supervisor

This block collects the digitized fault comparators of a switching converter controller and turns them into one gate-enable signal. Each fault has its own policy. The supply lockout uses two separate comparator flags and holds its state between them. A supply overvoltage must persist through a debounce window before it acts, and it restarts by itself. An output overvoltage, sensed through the auxiliary winding, is latched. A current-sense level that indicates a shorted output diode acts only after several consecutive switching cycles. The over-temperature lockout releases through its own cool-down flag.

The surrounding controller ANDs `gate_en_o` into its gate driver path and returns one strobe per switching cycle. The five-bit status vector reports each fault cause separately.

Top module: `prot_supervisor`

## Requirements
- R1: While reset is active, and in the first cycle after it, `gate_en_o` is 0 and `fault_o` is 5'b00001. Bit 0 means lockout, bit 1 supply overvoltage, bit 2 output overvoltage, bit 3 diode short, and bit 4 over-temperature.
- R2: When `sup_rise_i` is sampled high at a clock edge, lockout bit 0 is clear after that edge. When neither supply flag is high, the bit keeps its value.
- R3: When `sup_fall_i` is sampled high at an edge, bit 0 is set after that edge. This holds even if `sup_rise_i` is high at the same edge.
- R4: Bit 1 is set after the edge at which `sup_ov_i` has been sampled high for OVP_DEB_CYC consecutive edges. A single low sample restarts that count.
- R5: Bit 1 clears after the first edge at which `sup_ov_i` is sampled low.
- R6: A high `out_ov_i` sets bit 2. The bit stays set, even through a new `sup_rise_i`, until `sup_fall_i` is sampled high. A clear has priority over a set.
- R7: Bit 3 is set after SHORT_CYC consecutive `gate_cyc_i` strobes that each see `cs_short_i` high. A strobe with `cs_short_i` low restarts the count. Edges without a strobe neither count nor restart. Only `sup_fall_i` clears the bit.
- R8: A high `temp_hot_i` sets bit 4. The bit clears only when `temp_cool_i` is high while `temp_hot_i` is low.
- R9: `gate_en_o` is 1 exactly when every bit of `fault_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_rise_i | input | 1 | Supply is above the turn-on level |
| sup_fall_i | input | 1 | Supply is below the turn-off level |
| sup_ov_i | input | 1 | Supply is above the overvoltage level |
| out_ov_i | input | 1 | Sampled auxiliary level is above the output-overvoltage level |
| cs_short_i | input | 1 | Current-sense level is above the diode-short level |
| gate_cyc_i | input | 1 | One-cycle strobe per switching cycle |
| temp_hot_i | input | 1 | Junction is above the shutdown temperature |
| temp_cool_i | input | 1 | Junction has cooled by the release hysteresis |
| gate_en_o | output | 1 | Gate may switch |
| fault_o | output | 5 | Fault status vector, bit order as in R1 |

## Verification
Every piece of fault state is registered, so a wrong latch or counter shows on `fault_o` and `gate_en_o` one edge after the stimulus that should have moved it. Some faults do not go away by themselves. If a latch clears too early, the bit drops while its cause is absent and no supply-fall has been seen. If a counter is off by one, the bit sets one sample early or late. A lost restart condition on the debounce or the cycle counter can only be seen by dropping the flag one sample short of the limit and then counting the full window again.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int FLT_W     = 5;
    localparam int FLT_LOCK  = 0;
    localparam int FLT_VDDOV = 1;
    localparam int FLT_OUTOV = 2;
    localparam int FLT_SHORT = 3;
    localparam int FLT_HOT   = 4;
endpackage

// File: rtl/prot_sr_latch.sv
module prot_sr_latch #(
    parameter bit SET_WINS = 1'b0,
    parameter bit INIT     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    typedef struct packed {
        logic q;
    } st_t;

    st_t st_d, st_q;

    generate
        if (SET_WINS) begin : g_set_pri
            always_comb begin
                st_d = st_q;
                if (set_i)      st_d.q = 1'b1;
                else if (clr_i) st_d.q = 1'b0;
            end
        end else begin : g_clr_pri
            always_comb begin
                st_d = st_q;
                if (clr_i)      st_d.q = 1'b0;
                else if (set_i) st_d.q = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{q: INIT};
        else        st_q <= st_d;
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/prot_debounce.sv
module prot_debounce #(
    parameter int CNT_MAX = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic flt_o
);
    localparam int CW = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!flag_i) begin
            st_d.cnt = '0;
            st_d.flt = 1'b0;
        end else if (st_q.cnt == CW'(CNT_MAX - 1)) begin
            st_d.flt = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_o = st_q.flt;
endmodule

// File: rtl/prot_cycle_count.sv
module prot_cycle_count #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic flt_o
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (!st_q.flt && strobe_i) begin
            if (!hit_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CW'(N - 1)) begin
                st_d.flt = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_o = st_q.flt;
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import prot_pkg::*;
#(
    parameter int OVP_DEB_CYC = 1000,
    parameter int SHORT_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_rise_i,
    input  logic             sup_fall_i,
    input  logic             sup_ov_i,
    input  logic             out_ov_i,
    input  logic             cs_short_i,
    input  logic             gate_cyc_i,
    input  logic             temp_hot_i,
    input  logic             temp_cool_i,
    output logic             gate_en_o,
    output logic [FLT_W-1:0] fault_o
);
    logic run_q, vddov_q, outov_q, short_q, hot_q;

    prot_sr_latch #(.SET_WINS(1'b0), .INIT(1'b0)) u_run (
        .clk(clk), .rst_n(rst_n), .set_i(sup_rise_i), .clr_i(sup_fall_i), .q_o(run_q)
    );

    prot_debounce #(.CNT_MAX(OVP_DEB_CYC)) u_vddov (
        .clk(clk), .rst_n(rst_n), .flag_i(sup_ov_i), .flt_o(vddov_q)
    );

    prot_sr_latch #(.SET_WINS(1'b0), .INIT(1'b0)) u_outov (
        .clk(clk), .rst_n(rst_n), .set_i(out_ov_i), .clr_i(sup_fall_i), .q_o(outov_q)
    );

    prot_cycle_count #(.N(SHORT_CYC)) u_short (
        .clk(clk), .rst_n(rst_n), .strobe_i(gate_cyc_i), .hit_i(cs_short_i),
        .clr_i(sup_fall_i), .flt_o(short_q)
    );

    prot_sr_latch #(.SET_WINS(1'b1), .INIT(1'b0)) u_hot (
        .clk(clk), .rst_n(rst_n), .set_i(temp_hot_i), .clr_i(temp_cool_i), .q_o(hot_q)
    );

    always_comb begin
        fault_o            = '0;
        fault_o[FLT_LOCK]  = ~run_q;
        fault_o[FLT_VDDOV] = vddov_q;
        fault_o[FLT_OUTOV] = outov_q;
        fault_o[FLT_SHORT] = short_q;
        fault_o[FLT_HOT]   = hot_q;
    end

    assign gate_en_o = run_q & ~(vddov_q | outov_q | short_q | hot_q);
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk #(
    parameter int OVP_DEB_CYC = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_rise_i,
    input logic       sup_fall_i,
    input logic       sup_ov_i,
    input logic       out_ov_i,
    input logic       cs_short_i,
    input logic       gate_cyc_i,
    input logic       temp_hot_i,
    input logic       temp_cool_i,
    input logic       gate_en_o,
    input logic [4:0] fault_o
);
    int hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hi_cnt_q <= 0;
        else if (!sup_ov_i)           hi_cnt_q <= 0;
        else if (hi_cnt_q < OVP_DEB_CYC) hi_cnt_q <= hi_cnt_q + 1;
    end

    // R2
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o[0]) |-> $past(sup_rise_i));

    // R3
    lock_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_fall_i |=> fault_o[0]);

    // R4
    vddov_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[1] |-> (hi_cnt_q == OVP_DEB_CYC));

    // R5
    vddov_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ov_i |=> !fault_o[1]);

    // R6
    outov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ov_i && !sup_fall_i) |=> fault_o[2]);

    // R6
    outov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o[2] && !sup_fall_i) |=> fault_o[2]);

    // R7
    short_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o[3]) |-> $past(gate_cyc_i && cs_short_i));

    // R8
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_hot_i || (fault_o[4] && !temp_cool_i)) |=> fault_o[4]);

    // R9
    gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o == (fault_o == 5'b00000));
endmodule

bind prot_supervisor prot_supervisor_chk #(.OVP_DEB_CYC(OVP_DEB_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .sup_rise_i(sup_rise_i), .sup_fall_i(sup_fall_i),
    .sup_ov_i(sup_ov_i), .out_ov_i(out_ov_i), .cs_short_i(cs_short_i),
    .gate_cyc_i(gate_cyc_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
    .gate_en_o(gate_en_o), .fault_o(fault_o)
);

// File: tb/prot_supervisor_tb_top.sv
module prot_supervisor_tb_top;
    localparam int DEB  = 20;
    localparam int NSHT = 3;
    localparam int NVEC = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_rise_i = 0, sup_fall_i = 0, sup_ov_i = 0, out_ov_i = 0;
    logic cs_short_i = 0, gate_cyc_i = 0, temp_hot_i = 0, temp_cool_i = 0;
    logic       gate_en_o;
    logic [4:0] fault_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prot_supervisor #(.OVP_DEB_CYC(DEB), .SHORT_CYC(NSHT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sup_rise_i(sup_rise_i), .sup_fall_i(sup_fall_i),
        .sup_ov_i(sup_ov_i), .out_ov_i(out_ov_i), .cs_short_i(cs_short_i),
        .gate_cyc_i(gate_cyc_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
        .gate_en_o(gate_en_o), .fault_o(fault_o)
    );

    // vector: {rise,fall,sup_ov,out_ov,cs,strobe,hot,cool}, expected fault, expected enable, requirement
    localparam logic [13:0] VEC [NVEC] = '{
        {8'b0000_0000, 5'b00001, 1'b0},  // R2 hold in lockout
        {8'b1000_0000, 5'b00000, 1'b1},  // R2 release
        {8'b0000_0000, 5'b00000, 1'b1},  // R2 hold running
        {8'b1100_0000, 5'b00001, 1'b0},  // R3 fall wins
        {8'b1000_0000, 5'b00000, 1'b1},  // R2
        {8'b0001_0000, 5'b00100, 1'b0},  // R6 set
        {8'b0000_0000, 5'b00100, 1'b0},  // R6 latched
        {8'b1000_0000, 5'b00100, 1'b0},  // R6 rise does not clear
        {8'b0100_0000, 5'b00001, 1'b0},  // R6 fall clears
        {8'b1000_0000, 5'b00000, 1'b1},  // R2
        {8'b0000_1100, 5'b00000, 1'b1},  // R7 count 1
        {8'b0000_1100, 5'b00000, 1'b1},  // R7 count 2
        {8'b0000_1000, 5'b00000, 1'b1},  // R7 no strobe, not counted
        {8'b0000_0100, 5'b00000, 1'b1},  // R7 strobe without flag restarts
        {8'b0000_1100, 5'b00000, 1'b1},  // R7
        {8'b0000_1100, 5'b00000, 1'b1},  // R7
        {8'b0000_1100, 5'b01000, 1'b0},  // R7 third consecutive
        {8'b0000_0000, 5'b01000, 1'b0},  // R7 latched
        {8'b0000_0010, 5'b11000, 1'b0},  // R8 set
        {8'b0000_0011, 5'b11000, 1'b0},  // R8 hot wins over cool
        {8'b0000_0001, 5'b01000, 1'b0},  // R8 release
        {8'b0100_0000, 5'b00001, 1'b0},  // R7 cleared by fall
        {8'b1000_0000, 5'b00000, 1'b1}   // R9 all clear
    };
    localparam int VREQ [NVEC] = '{2,2,2,3,2,6,6,6,6,2,7,7,7,7,7,7,7,7,8,8,8,7,9};

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        {sup_rise_i, sup_fall_i, sup_ov_i, out_ov_i, cs_short_i, gate_cyc_i,
         temp_hot_i, temp_cool_i} = v;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input int req, input logic [4:0] ef, input logic een);
        checks++;
        if (fault_o !== ef || gate_en_o !== een) begin
            errors++;
            $display("FAIL R%0d: fault=%b en=%b expected fault=%b en=%b",
                     req, fault_o, gate_en_o, ef, een);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check(1, 5'b00001, 1'b0);  // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'b0);
        check(1, 5'b00001, 1'b0);  // R1 first cycle after reset

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][13:6]);
            check(VREQ[i], VEC[i][5:1], VEC[i][0]);
        end

        // R4: one sample short, then drop, then full window again
        for (int i = 0; i < DEB - 1; i++) drive(8'b0010_0000);
        check(4, 5'b00000, 1'b1);
        drive(8'b0);
        check(4, 5'b00000, 1'b1);
        for (int i = 0; i < DEB - 1; i++) drive(8'b0010_0000);
        check(4, 5'b00000, 1'b1);
        drive(8'b0010_0000);
        check(4, 5'b00010, 1'b0);
        drive(8'b0010_0000);
        check(4, 5'b00010, 1'b0);
        // R5 auto-restart
        drive(8'b0);
        check(5, 5'b00000, 1'b1);

        // R1 reset in the middle of a fault
        drive(8'b0001_0000);
        check(6, 5'b00100, 1'b0);
        @(negedge clk);
        {sup_rise_i, sup_fall_i, sup_ov_i, out_ov_i, cs_short_i, gate_cyc_i,
         temp_hot_i, temp_cool_i} = 8'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check(1, 5'b00001, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'b0);
        check(1, 5'b00001, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule